// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block is a bank of 32-bit configuration registers placed in a 4 KB window and accessed over a plain word-addressed bus. The bus has one request per cycle, a write strobe, and combinational read data. A lock flag guards the configuration registers. The flag comes out of reset set. While it is set, configuration writes are dropped. Two write-only registers change the flag, and each acts only when the low 16 bits of the written word equal its own key.

Every offset has one access class: read-write, read-only, write-only, or none. An access in a forbidden direction gives a one-cycle error pulse in the same cycle as the access. A write that is not allowed changes nothing. Reads that are not allowed return zero. Bit 0 of the reset-control register starts a system soft reset: an accepted write with that bit set gives a one-cycle request on the cycle after the write. The register contents have no other effect in this block. It models storage, reset values and access policy only.

Top module: `keylock_regfile`

## Requirements
- R1: After reset, the lock status register (byte offset 0x00C, bit 0 = lock flag) reads 1.
- R2: A write to byte offset 0x008 clears the lock flag when data[15:0] = 0xDF0D, and the upper bits are ignored. Any other key leaves the flag unchanged and raises no error.
- R3: A write to byte offset 0x004 sets the lock flag when data[15:0] = 0x767B. Any other key leaves the flag unchanged and raises no error.
- R4: While the lock flag is set, a write to any read-write register other than offset 0x000 is dropped and pulses bus_err. While the flag is clear, the same write is stored without error.
- R5: A write to offset 0x000 stores only data bit 0. Reads return it in bit 0 with all other bits zero. The write is accepted, without error, whether or not the flag is set.
- R6: The registers at 0x004 and 0x008 are write-only: a read pulses bus_err and returns 0. The registers at 0x00C, 0x10C, 0x25C and 0x530 are read-only: a write pulses bus_err and changes nothing. A read of 0x530 returns the ID_VALUE parameter.
- R7: An access to an offset outside the defined map pulses bus_err. A read returns 0 and a write is dropped. The unmapped offsets include 0x0FC, 0x7D8 and 0xFFC.
- R8: The PLL control registers at 0x100, 0x104 and 0x108 reset to 0x0001A008. The PLL status register at 0x10C reads 0x0000003F. The boot-mode register at 0x25C reads 0x00000001.
- R9: The pin-multiplex entries at 0x700 + 4*i, for i from 0 to PINMUX_N-1, are read-write. Entries 2 to 8 reset to 0x00000601 and the other entries reset to 0x00001601.
- R10: An accepted write to 0x200 stores the full word. If bit 0 is set, soft_rst_req is high for exactly the one cycle after the write. A write with bit 0 clear, or a write that is dropped while locked, gives no request.
- R11: An allowed access raises no bus_err, and bus_err is high only in the cycle of the offending access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Illegal-access pulse, same cycle as the access |
| soft_rst_req | output | 1 | One-cycle system soft reset request |

## Verification
The bench uses the default parameters: a 10-bit word address, which spans the whole 4 KB window, and 54 pin-multiplex entries. With these values it can reach the top word of the window and the first word past the last pin-multiplex entry. Both are unmapped offsets on either side of a live range. The bench also reads the two boundaries of the 0x601 reset group, entries 2 and 8, together with their neighbours. It checks the soft-reset request on the cycle after the triggering write and again on the cycle after that.

// File: rtl/keylock_regfile.sv
module keylock_regfile #(
  parameter int          ADDR_W   = 10,
  parameter int          PINMUX_N = 54,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              soft_rst_req
);
  localparam int MUX_IW = $clog2(PINMUX_N);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_UNL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(32'h40);
  localparam logic [ADDR_W-1:0] A_PST  = ADDR_W'(32'h43);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(32'h80);
  localparam logic [ADDR_W-1:0] A_BOOT = ADDR_W'(32'h97);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(32'h14C);
  localparam logic [ADDR_W-1:0] A_MUX  = ADDR_W'(32'h1C0);
  localparam logic [ADDR_W-1:0] A_MEND = ADDR_W'(32'h1C0 + PINMUX_N);
  localparam logic [15:0] KEY_LOCK = 16'h767B;
  localparam logic [15:0] KEY_UNL  = 16'hDF0D;

  logic        locked;
  logic        ctl_q;
  logic [31:0] pll_q [3];
  logic [31:0] rst_q;
  logic [31:0] mux_q [PINMUX_N];
  logic        srst_q;

  wire hit_pll = (bus_addr >= A_PLL) && (bus_addr < A_PST);
  wire hit_mux = (bus_addr >= A_MUX) && (bus_addr < A_MEND);
  wire hit_ro  = (bus_addr == A_STA) || (bus_addr == A_PST) ||
                 (bus_addr == A_BOOT) || (bus_addr == A_ID);
  wire hit_wo  = (bus_addr == A_LOCK) || (bus_addr == A_UNL);
  wire hit_rw  = (bus_addr == A_CTL) || (bus_addr == A_RST) || hit_pll || hit_mux;
  wire unmapped = !(hit_ro || hit_wo || hit_rw);

  wire [ADDR_W-1:0] mux_off = bus_addr - A_MUX;
  wire [MUX_IW-1:0] mux_sel = mux_off[MUX_IW-1:0];
  wire [1:0]        pll_sel = bus_addr[1:0];

  wire is_wr  = bus_valid && bus_write;
  wire gated  = locked && (bus_addr != A_CTL);
  wire wr_ok  = is_wr && hit_rw && !gated;

  assign bus_err = bus_valid && (bus_write ? (hit_ro || unmapped || (hit_rw && gated))
                                           : (hit_wo || unmapped));
  assign soft_rst_req = srst_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (bus_addr == A_CTL)       bus_rdata = {31'd0, ctl_q};
      else if (bus_addr == A_STA)  bus_rdata = {31'd0, locked};
      else if (hit_pll)            bus_rdata = pll_q[pll_sel];
      else if (bus_addr == A_PST)  bus_rdata = 32'h0000_003F;
      else if (bus_addr == A_RST)  bus_rdata = rst_q;
      else if (bus_addr == A_BOOT) bus_rdata = 32'h0000_0001;
      else if (bus_addr == A_ID)   bus_rdata = ID_VALUE;
      else if (hit_mux)            bus_rdata = mux_q[mux_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1;
      ctl_q  <= 1'b0;
      rst_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      if (is_wr && bus_addr == A_LOCK && bus_wdata[15:0] == KEY_LOCK) locked <= 1'b1;
      if (is_wr && bus_addr == A_UNL  && bus_wdata[15:0] == KEY_UNL)  locked <= 1'b0;
      if (wr_ok && bus_addr == A_CTL) ctl_q <= bus_wdata[0];
      if (wr_ok && bus_addr == A_RST) rst_q <= bus_wdata;
      srst_q <= wr_ok && (bus_addr == A_RST) && bus_wdata[0];
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_pll
    always_ff @(posedge clk) begin
      if (!rst_n) pll_q[p] <= 32'h0001_A008;
      else if (wr_ok && hit_pll && pll_sel == 2'(p)) pll_q[p] <= bus_wdata;
    end
  end

  for (genvar i = 0; i < PINMUX_N; i++) begin : g_mux
    localparam logic [31:0] RV = (i >= 2 && i <= 8) ? 32'h0000_0601 : 32'h0000_1601;
    always_ff @(posedge clk) begin
      if (!rst_n) mux_q[i] <= RV;
      else if (wr_ok && hit_mux && mux_sel == MUX_IW'(i)) mux_q[i] <= bus_wdata;
    end
  end

  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_addr == A_LOCK && bus_wdata[15:0] == KEY_LOCK) |=> locked);
  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_addr == A_UNL && bus_wdata[15:0] == KEY_UNL) |=> !locked);
  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_addr == A_UNL && bus_wdata[15:0] != KEY_UNL) |=> $stable(locked));
  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && is_wr && bus_addr == A_PLL) |=> $stable(pll_q[0]));
  p_locked_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && is_wr && bus_addr == A_PLL) |-> bus_err);
  p_ctl_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_addr == A_CTL) |-> !bus_err);
  p_wo_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == A_LOCK) |-> (bus_err && bus_rdata == 32'd0));
  p_srst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> !soft_rst_req);
  p_srst_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> (rst_q[0] && !locked));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !bus_err);
endmodule

// File: tb/sim_keylock_regfile.sv
module sim_keylock_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        soft_rst_req;

  localparam logic [31:0] ID = 32'h0A5C_0001;

  keylock_regfile #(.ADDR_W(10), .PINMUX_N(54), .ID_VALUE(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .soft_rst_req(soft_rst_req));

  always #5 clk = ~clk;

  typedef struct {
    logic        chk_rd;
    logic [31:0] rd;
    logic        err;
    logic        srst;
    string       tag;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  logic pend = 1'b0;
  logic done = 1'b0;

  task automatic acc(input logic wr, input logic [11:0] off, input logic [31:0] d,
                     input logic [31:0] exp_rd, input logic exp_err,
                     input logic srst_next, input string tag);
    item_t it;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = off[11:2]; bus_wdata = d;
    it.chk_rd = !wr; it.rd = exp_rd; it.err = exp_err; it.srst = pend; it.tag = tag;
    pend = srst_next;
    q.push_back(it);
  endtask

  task automatic rd(input logic [11:0] off, input logic [31:0] exp_rd,
                    input logic exp_err, input string tag);
    acc(1'b0, off, 32'd0, exp_rd, exp_err, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d,
                    input logic exp_err, input string tag);
    acc(1'b1, off, d, 32'd0, exp_err, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    item_t it;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    it.chk_rd = 1'b0; it.rd = 32'd0; it.err = 1'b0; it.srst = pend; it.tag = tag;
    pend = 1'b0;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        it = q.pop_front();
        compared++;
        if (bus_err !== it.err || soft_rst_req !== it.srst ||
            (it.chk_rd && bus_rdata !== it.rd)) begin
          mismatched++;
          $display("FAIL %s: rdata=%h err=%b srst=%b expected rdata=%h err=%b srst=%b",
                   it.tag, bus_rdata, bus_err, soft_rst_req, it.rd, it.err, it.srst);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset lock state
    rd(12'h00C, 32'd1, 1'b0, "R1 lock status after reset");
    // R8 reset values
    rd(12'h100, 32'h0001_A008, 1'b0, "R8 pll0 reset");
    rd(12'h104, 32'h0001_A008, 1'b0, "R8 pll1 reset");
    rd(12'h108, 32'h0001_A008, 1'b0, "R8 pll2 reset");
    rd(12'h10C, 32'h0000_003F, 1'b0, "R8 pll status");
    rd(12'h25C, 32'h0000_0001, 1'b0, "R8 boot mode");
    // R9 pin-mux reset groups
    rd(12'h700, 32'h0000_1601, 1'b0, "R9 mux0");
    rd(12'h704, 32'h0000_1601, 1'b0, "R9 mux1");
    rd(12'h708, 32'h0000_0601, 1'b0, "R9 mux2");
    rd(12'h720, 32'h0000_0601, 1'b0, "R9 mux8");
    rd(12'h724, 32'h0000_1601, 1'b0, "R9 mux9");
    rd(12'h7D4, 32'h0000_1601, 1'b0, "R9 mux53");
    // R4 locked writes dropped
    wr(12'h100, 32'h1234_5678, 1'b1, "R4 locked pll write err");
    rd(12'h100, 32'h0001_A008, 1'b0, "R4 locked pll unchanged");
    wr(12'h70C, 32'h0000_00AA, 1'b1, "R4 locked mux write err");
    rd(12'h70C, 32'h0000_0601, 1'b0, "R4 locked mux unchanged");
    // R5 offset 0 bit 0 only, ignores lock
    wr(12'h000, 32'hFFFF_FFFF, 1'b0, "R5 ctl write while locked");
    rd(12'h000, 32'h0000_0001, 1'b0, "R5 ctl keeps bit0");
    wr(12'h000, 32'h0000_0002, 1'b0, "R5 ctl write bit1 only");
    rd(12'h000, 32'h0000_0000, 1'b0, "R5 ctl bit0 cleared");
    // R2 unlock protocol
    wr(12'h008, 32'h0000_1234, 1'b0, "R2 wrong unlock key");
    rd(12'h00C, 32'd1, 1'b0, "R2 still locked");
    wr(12'h008, 32'hABCD_DF0D, 1'b0, "R2 unlock key");
    rd(12'h00C, 32'd0, 1'b0, "R2 unlocked");
    // R4/R11 unlocked writes accepted
    wr(12'h100, 32'hCAFE_0001, 1'b0, "R11 unlocked pll write");
    rd(12'h100, 32'hCAFE_0001, 1'b0, "R4 pll stored when unlocked");
    rd(12'h104, 32'h0001_A008, 1'b0, "R4 pll1 untouched");
    wr(12'h714, 32'h0000_0055, 1'b0, "R11 mux5 write");
    rd(12'h714, 32'h0000_0055, 1'b0, "R9 mux5 read-write");
    // R6 access classes
    rd(12'h004, 32'd0, 1'b1, "R6 read lock reg");
    rd(12'h008, 32'd0, 1'b1, "R6 read unlock reg");
    wr(12'h10C, 32'h0, 1'b1, "R6 write pll status");
    rd(12'h10C, 32'h0000_003F, 1'b0, "R6 pll status unchanged");
    wr(12'h25C, 32'h7, 1'b1, "R6 write boot mode");
    rd(12'h25C, 32'h0000_0001, 1'b0, "R6 boot mode unchanged");
    wr(12'h00C, 32'h1, 1'b1, "R6 write lock status");
    rd(12'h00C, 32'd0, 1'b0, "R6 lock status unchanged");
    wr(12'h530, 32'h0, 1'b1, "R6 write id");
    rd(12'h530, ID, 1'b0, "R6 id read");
    // R7 unmapped
    rd(12'h0FC, 32'd0, 1'b1, "R7 read 0x0FC");
    wr(12'h0FC, 32'h1, 1'b1, "R7 write 0x0FC");
    rd(12'h7D8, 32'd0, 1'b1, "R7 read past mux");
    wr(12'h7D8, 32'h5, 1'b1, "R7 write past mux");
    rd(12'h7D4, 32'h0000_1601, 1'b0, "R7 mux53 untouched");
    rd(12'hFFC, 32'd0, 1'b1, "R7 read top word");
    idle("R11 idle no err");
    // R10 soft reset
    wr(12'h200, 32'h0000_0010, 1'b0, "R10 rst ctl bit0 clear");
    idle("R10 no request for bit0 clear");
    rd(12'h200, 32'h0000_0010, 1'b0, "R10 rst ctl stored");
    acc(1'b1, 12'h200, 32'h0000_0003, 32'd0, 1'b0, 1'b1, "R10 rst ctl trigger");
    idle("R10 request pulse");
    idle("R10 request one cycle");
    rd(12'h200, 32'h0000_0003, 1'b0, "R10 rst ctl value");
    // R3 lock protocol
    wr(12'h004, 32'h0000_767A, 1'b0, "R3 wrong lock key");
    rd(12'h00C, 32'd0, 1'b0, "R3 still unlocked");
    wr(12'h004, 32'hFFFF_767B, 1'b0, "R3 lock key");
    rd(12'h00C, 32'd1, 1'b0, "R3 locked");
    wr(12'h200, 32'h0000_0001, 1'b1, "R10 locked rst write err");
    idle("R10 no request while locked");
    rd(12'h200, 32'h0000_0003, 1'b0, "R4 rst ctl unchanged while locked");
    idle("drain");
    wait (q.size() == 0);
    #20;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule